// File: doc/BRIEF.md
# Sa-Bit Far-End CRC Error Indication Counter

This block sits in the receive path of an E1 line using the CRC-4 multiframe. The far end reports CRC errors it has detected by sending 4-bit codes on one of the spare Sa bits (Sa4..Sa8) of the frames that carry no frame alignment signal. The block collects the selected Sa bit across the four such frames of each submultiframe and builds a 4-bit word from them. It compares the word with the active pair of error codes. When the word matches, it adds one to a 16-bit event count.

The framer supplies three things: a strobe with the five Sa bits of each non-alignment frame, a pulse at every submultiframe boundary, and the multiframe-synchronous status. Software picks the Sa position and the code mode. In the standard mode the error codes are fixed. In the user mode they are two programmable values. The count is reported through a read request. The request copies the live count into a holding register, which drives the output, and clears the live count in the same cycle.

Top module: `sa_crc_err_monitor`

## Requirements
- R1: After reset, `count_o` is 0 and the live count is 0.
- R2: With `code_mode_i`=0, the words 4'b0001 and 4'b0011 are counted, and the other 14 words are not.
- R3: With `code_mode_i`=1, a word is counted only if it equals `code_a_i` or `code_b_i`. The standard codes lose their meaning in this mode.
- R4: `sa_bits_i[k]` carries Sa(4+k). `sa_sel_i` values 0..4 select `sa_bits_i[sa_sel_i]`, and values 5..7 select Sa8. The first strobe after `smf_start_i` supplies the word's MSB.
- R5: An increment needs `mf_sync_i` high at three points: when `smf_start_i` opens the submultiframe, for every cycle up to the fourth strobe, and in the cycle the count is updated. A submultiframe opened or interrupted outside sync is discarded.
- R6: The live count saturates at all ones and never wraps.
- R7: A read (`rd_req_i` high for one cycle) copies the live count into `count_o` and restarts the live count at 0. If an increment falls in the same cycle, the copied value excludes it and the new live count is 1. An increment shows in the live count at the second rising edge after the fourth strobe is sampled.
- R8: Strobes after the fourth in a submultiframe are ignored. A submultiframe with fewer than four strobes is dropped when the next `smf_start_i` arrives. A strobe in the same cycle as `smf_start_i` is the first bit of the new submultiframe.
- R9: `count_o` changes only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sa_bits_i | input | 5 | Sa4..Sa8 of the current non-alignment frame (bit 0 = Sa4) |
| sa_valid_i | input | 1 | Strobe: `sa_bits_i` is valid this cycle |
| smf_start_i | input | 1 | Submultiframe boundary pulse |
| mf_sync_i | input | 1 | Receiver is CRC-4 multiframe synchronous |
| sa_sel_i | input | 3 | Sa position select (0 = Sa4 ... 4 = Sa8) |
| code_mode_i | input | 1 | 0: standard codes, 1: programmable codes |
| code_a_i | input | 4 | First programmable code |
| code_b_i | input | 4 | Second programmable code |
| rd_req_i | input | 1 | Latch the count to the output and clear the live count |
| count_o | output | 16 | Count latched by the last read |

## Verification
The counter update and the read can fall in the same cycle. A matching word completes its increment in exactly the cycle in which a read clears the live count. The bench provokes this by raising `rd_req_i` in the cycle right after the fourth strobe of a matching submultiframe. It then judges the result with two reads: the first must return the old count without the increment, and the second must return 1. A second case is a strobe arriving together with a boundary pulse. It must start the new word, and the partial word of the old submultiframe must be dropped.

// File: rtl/sa_err_pkg.sv
package sa_err_pkg;
  localparam int unsigned SA_CODE_W = 4;
  localparam logic [SA_CODE_W-1:0] STD_CODE_A = 4'b0001;
  localparam logic [SA_CODE_W-1:0] STD_CODE_B = 4'b0011;
  localparam int unsigned NUM_CODES = 2;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_USER = 1'b1
  } code_mode_e;
endpackage

// File: rtl/sa_nibble_collector.sv
module sa_nibble_collector #(
  parameter int unsigned NUM_SA = 5,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SA-1:0] sa_bits_i,
  input  logic              sa_valid_i,
  input  logic              smf_start_i,
  input  logic              mf_sync_i,
  input  logic [SEL_W-1:0]  sa_sel_i,
  output logic [CODE_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned BC_W = $clog2(CODE_W + 1);
  localparam logic [BC_W-1:0] LAST_IDX = BC_W'(CODE_W - 1);
  localparam logic [BC_W-1:0] FULL_CNT = BC_W'(CODE_W);

  logic              sel_bit;
  logic [CODE_W-1:0] shreg_q, next_word;
  logic [BC_W-1:0]   bit_cnt_q;
  logic              smf_ok_q;

  // Out-of-range select falls back to the highest Sa position
  always_comb begin
    sel_bit = sa_bits_i[NUM_SA-1];
    for (int i = 0; i < NUM_SA; i++) begin
      if (sa_sel_i == SEL_W'(i)) sel_bit = sa_bits_i[i];
    end
  end

  assign next_word = {shreg_q[CODE_W-2:0], sel_bit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      bit_cnt_q  <= '0;
      smf_ok_q   <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (smf_start_i) begin
        smf_ok_q  <= mf_sync_i;
        bit_cnt_q <= sa_valid_i ? BC_W'(1) : '0;
        shreg_q   <= sa_valid_i ? CODE_W'(sel_bit) : '0;
      end else begin
        if (!mf_sync_i) smf_ok_q <= 1'b0;
        if (sa_valid_i && (bit_cnt_q < FULL_CNT)) begin
          shreg_q   <= next_word;
          bit_cnt_q <= bit_cnt_q + BC_W'(1);
          if (bit_cnt_q == LAST_IDX) begin
            word_o     <= next_word;
            word_vld_o <= smf_ok_q && mf_sync_i;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sa_code_matcher.sv
module sa_code_matcher
  import sa_err_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] word_i,
  input  code_mode_e        mode_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  output logic              match_o
);
  logic [CODE_W-1:0]    codes [NUM_CODES];
  logic [NUM_CODES-1:0] hit;

  always_comb begin
    if (mode_i == MODE_USER) begin
      codes[0] = code_a_i;
      codes[1] = code_b_i;
    end else begin
      codes[0] = CODE_W'(STD_CODE_A);
      codes[1] = CODE_W'(STD_CODE_B);
    end
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
    assign hit[g] = (word_i == codes[g]);
  end

  assign match_o = |hit;
endmodule

// File: rtl/sa_event_counter.sv
module sa_event_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_req_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] live_d;

  always_comb begin
    live_d = live_o;
    if (rd_req_i)                         live_d = inc_i ? CNT_W'(1) : '0;
    else if (inc_i && (live_o != CNT_MAX)) live_d = live_o + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o <= '0;
      hold_o <= '0;
    end else begin
      live_o <= live_d;
      if (rd_req_i) hold_o <= live_o;
    end
  end
endmodule

// File: rtl/sa_crc_err_monitor.sv
module sa_crc_err_monitor
  import sa_err_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = SA_CODE_W,
  parameter int unsigned NUM_SA = 5,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SA-1:0] sa_bits_i,
  input  logic              sa_valid_i,
  input  logic              smf_start_i,
  input  logic              mf_sync_i,
  input  logic [SEL_W-1:0]  sa_sel_i,
  input  logic              code_mode_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic              rd_req_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [CODE_W-1:0] word;
  logic              word_vld, match, inc;
  logic [CNT_W-1:0]  live_cnt;
  code_mode_e        mode;

  assign mode = code_mode_e'(code_mode_i);

  sa_nibble_collector #(
    .NUM_SA (NUM_SA),
    .SEL_W  (SEL_W),
    .CODE_W (CODE_W)
  ) i_collector (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sa_bits_i   (sa_bits_i),
    .sa_valid_i  (sa_valid_i),
    .smf_start_i (smf_start_i),
    .mf_sync_i   (mf_sync_i),
    .sa_sel_i    (sa_sel_i),
    .word_o      (word),
    .word_vld_o  (word_vld)
  );

  sa_code_matcher #(
    .CODE_W (CODE_W)
  ) i_matcher (
    .word_i   (word),
    .mode_i   (mode),
    .code_a_i (code_a_i),
    .code_b_i (code_b_i),
    .match_o  (match)
  );

  // Sync must still hold when the count is updated
  assign inc = word_vld && match && mf_sync_i;

  sa_event_counter #(
    .CNT_W (CNT_W)
  ) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .rd_req_i (rd_req_i),
    .live_o   (live_cnt),
    .hold_o   (count_o)
  );
endmodule

// File: rtl/sa_crc_err_monitor_chk.sv
module sa_crc_err_monitor_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_req_i,
  input logic             mf_sync_i,
  input logic [CNT_W-1:0] live_i,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_out_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(count_o));

  assert_latch_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (count_o == $past(live_i)));

  assert_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> (live_i <= CNT_W'(1)));

  assert_no_count_unsynced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_sync_i && !rd_req_i) |=> $stable(live_i));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i == CNT_MAX && !rd_req_i) |=> (live_i == CNT_MAX));

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> (live_i == $past(live_i) || live_i == $past(live_i) + CNT_W'(1)));
endmodule

bind sa_crc_err_monitor sa_crc_err_monitor_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_i  (rd_req_i),
  .mf_sync_i (mf_sync_i),
  .live_i    (live_cnt),
  .count_o   (count_o)
);

// File: tb/test_sa_crc_err_monitor.sv
`timescale 1ns/1ps
module test_sa_crc_err_monitor;
  localparam int SAT_W = 6;
  localparam int SAT_MAX = (1 << SAT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sa_bits = '0;
  logic        sa_valid = 1'b0, smf_start = 1'b0, mf_sync = 1'b0;
  logic [2:0]  sa_sel = 3'd2;
  logic        mode = 1'b0;
  logic [3:0]  code_a = '0, code_b = '0;
  logic        rd_req = 1'b0;
  logic [15:0] count;
  logic [SAT_W-1:0] count_sat;

  int checks = 0, failures = 0;
  int exp_live = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sa_crc_err_monitor i_sa_crc_err_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sa_bits_i(sa_bits), .sa_valid_i(sa_valid),
    .smf_start_i(smf_start), .mf_sync_i(mf_sync), .sa_sel_i(sa_sel),
    .code_mode_i(mode), .code_a_i(code_a), .code_b_i(code_b),
    .rd_req_i(rd_req), .count_o(count));

  sa_crc_err_monitor #(.CNT_W(SAT_W)) i_sa_crc_err_monitor_sat (
    .clk_i(clk), .rst_ni(rst_n), .sa_bits_i(sa_bits), .sa_valid_i(sa_valid),
    .smf_start_i(smf_start), .mf_sync_i(mf_sync), .sa_sel_i(sa_sel),
    .code_mode_i(mode), .code_a_i(code_a), .code_b_i(code_b),
    .rd_req_i(rd_req), .count_o(count_sat));

  function automatic bit is_err(logic [3:0] w, bit m, logic [3:0] a, logic [3:0] b);
    return m ? (w == a || w == b) : (w == 4'b0001 || w == 4'b0011);
  endfunction

  function automatic int sel_idx(logic [2:0] s);
    return (s > 3'd4) ? 4 : int'(s);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_smf();
    @(negedge clk) smf_start = 1'b1;
    @(negedge clk) smf_start = 1'b0;
  endtask

  task automatic put_bit(logic b);
    logic [4:0] v;
    v = 5'($urandom);
    v[sel_idx(sa_sel)] = b;
    @(negedge clk) begin sa_valid = 1'b1; sa_bits = v; end
    @(negedge clk) sa_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Full submultiframe with a constant sync level; model updated here
  task automatic send_word(logic [3:0] w);
    start_smf();
    for (int i = 3; i >= 0; i--) put_bit(w[i]);
    idle(3);
    if (mf_sync && is_err(w, mode, code_a, code_b)) exp_live++;
  endtask

  task automatic do_read(string req);
    int exp_sat;
    exp_sat = (exp_live > SAT_MAX) ? SAT_MAX : exp_live;
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    check(req, int'(count), exp_live);
    check({req, "/R6 sat"}, int'(count_sat), exp_sat);
    exp_live = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5a6);
    idle(2);
    // R1: reset state
    check("R1 count after reset", int'(count), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    check("R1 count after release", int'(count), 0);
    mf_sync = 1'b1;

    // R2: every code in standard mode on Sa6
    for (int w = 0; w < 16; w++) send_word(4'(w));
    check("R9 no change without read", int'(count), 0);
    do_read("R2 standard codes");

    // R3: programmable codes, standard ones must not count
    mode = 1'b1; code_a = 4'b0101; code_b = 4'b1110;
    for (int w = 0; w < 16; w++) send_word(4'(w));
    do_read("R3 user codes");
    mode = 1'b0;

    // R4: position select incl. out-of-range value
    sa_sel = 3'd0; send_word(4'b0011); send_word(4'b1100);
    sa_sel = 3'd4; send_word(4'b0001);
    sa_sel = 3'd7; send_word(4'b0011); send_word(4'b1000);
    do_read("R4 position select");
    sa_sel = 3'd2;

    // R5: started out of sync, sync rises mid-word -> discarded
    mf_sync = 1'b0;
    start_smf();
    put_bit(1'b0); mf_sync = 1'b1;
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    idle(3);
    // R5: sync lost mid-word and regained -> discarded
    start_smf();
    put_bit(1'b0); mf_sync = 1'b0; put_bit(1'b0); mf_sync = 1'b1;
    put_bit(1'b1); put_bit(1'b1);
    idle(3);
    mf_sync = 1'b0; send_word(4'b0001);
    mf_sync = 1'b1;
    do_read("R5 sync gating");

    // R8: extra strobes ignored
    start_smf();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    idle(3); exp_live++;
    // R8: partial word dropped; strobe together with boundary is first bit
    start_smf();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    @(negedge clk) begin
      smf_start = 1'b1; sa_valid = 1'b1; sa_bits = '0;
    end
    @(negedge clk) begin smf_start = 1'b0; sa_valid = 1'b0; end
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    idle(3); exp_live++;
    do_read("R8 strobe count");

    // R7: read in the very cycle the increment lands
    send_word(4'b0001); send_word(4'b0011);
    start_smf();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    @(negedge clk) begin sa_valid = 1'b1; sa_bits = '1; sa_bits[2] = 1'b1; end
    @(negedge clk) begin sa_valid = 1'b0; rd_req = 1'b1; end
    @(negedge clk) rd_req = 1'b0;
    check("R7 latched without same-cycle inc", int'(count), 2);
    exp_live = 1;
    do_read("R7 same-cycle inc kept");

    // R6: saturate the narrow instance
    for (int i = 0; i < 70; i++) send_word((i % 2) ? 4'b0001 : 4'b0011);
    do_read("R6 saturation");

    // Random mix
    for (int n = 0; n < 120; n++) begin
      logic [3:0] w;
      @(negedge clk);
      mode    = 1'($urandom);
      code_a  = 4'($urandom);
      code_b  = 4'($urandom);
      sa_sel  = 3'($urandom);
      mf_sync = ($urandom % 5) != 0;
      case ($urandom % 3)
        0: w = mode ? code_a : 4'b0001;
        1: w = mode ? code_b : 4'b0011;
        default: w = 4'($urandom);
      endcase
      send_word(w);
      if (n % 20 == 19) do_read("R2/R3/R4/R5 random");
    end
    mf_sync = 1'b1;
    do_read("R2/R3 random tail");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule